// File: doc/BRIEF.md
# Palette and Pixel Serializer

This block turns two video bytes per character into sixteen colour codes, one per pixel slot, following the active graphics mode and a programmable palette. The host CPU programs it through I/O writes. These writes select an entry (one of sixteen pens, or the border), load a 5-bit hardware colour number into that entry, or set the graphics mode for the next commit. The output is one 5-bit hardware colour code per clock, and each clock is one pixel slot.

The block runs on the pixel slot clock, 16 slots per character. A slot counter runs freely from reset. The two video bytes are sampled in the last slot of a character and displayed across the whole next character. Palette writes go into a staging copy first. The displayed copy takes the staging copy at each half-character boundary, so a change made during a character shows from its ninth slot or from the first slot of the next character. A new mode waits until the sync logic pulses the commit strobe. Display-enable low shows the border. Force-black overrides everything with colour 20.

Top module: `palette_serializer`

## Requirements
- R1: An I/O write takes effect only when io_addr[15] is 0 and io_addr[14] is 1; all other address bits are ignored, and a write whose address fails this test changes no entry, selection or mode.
- R2: Data with bits 7:6 = 00 selects an entry: bit 4 = 1 selects the border, otherwise bits 3:0 select pen 0..15; the selection persists across any number of later colour writes until another select command.
- R3: Data with bits 7:6 = 01 writes data bits 4:0 as the colour number of the currently selected entry.
- R4: Data with bits 7:5 = 100 stores bits 1:0 as the pending mode; the displayed mode takes the pending value only in a cycle where mode_commit is high. Data with bits 7:5 = 101 or bits 7:6 = 11 has no effect.
- R5: The slot counter is 0 in the first cycle after reset and counts 0..15 cyclically. The bytes presented in slot 15 are displayed in slots 0..15 of the next character: vid_byte_a in slots 0..7 and vid_byte_b in slots 8..15. colour shows the result for a cycle's inputs one clock later.
- R6: Mode 0: each byte gives two pixels of four slots each. The first pixel's pen index is bit0=b7, bit1=b3, bit2=b5, bit3=b1. The second pixel's index is bit0=b6, bit1=b2, bit2=b4, bit3=b0.
- R7: Mode 1: each byte gives four pixels of two slots each. Pixel k (k = 0..3) has index bit 0 = b(7-k) and index bit 1 = b(3-k), so it uses pens 0..3.
- R8: Mode 2: each byte gives eight one-slot pixels, most significant bit first, using pens 0 and 1.
- R9: Mode 3: each byte gives two pixels of four slots each. The first pixel uses bit0=b7 and bit1=b3, the second uses bit0=b6 and bit1=b2, so pens 0..3 are used.
- R10: The displayed palette takes the staged values at the end of slot 7 and at the end of slot 15. A colour write made in slots 0..6 shows from slot 8, and one made in slots 8..14 shows from the next slot 0.
- R11: When force_blk is high, the output is colour 20. When force_blk is low and disp_en is low, the output is the border colour.
- R12: After reset, colour is 20, all 17 entries hold 20, the selection is pen 0, and both the pending and the displayed mode are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel slot clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O write address |
| io_data | input | 8 | I/O write data (command and payload) |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| vid_byte_a | input | 8 | First video byte of the character |
| vid_byte_b | input | 8 | Second video byte of the character |
| disp_en | input | 1 | High in the active area, low shows the border |
| force_blk | input | 1 | Forces colour 20 (black) |
| mode_commit | input | 1 | Moves the pending mode into the displayed mode |
| colour | output | 5 | Hardware colour number for the pixel slot |

## Verification
The assertions check the timing structure on every cycle. Writes to foreign addresses leave all register state untouched, and the slot counter wraps from 15 to 0. The video bytes and the displayed mode change only at the slot-15 capture and at a commit. The displayed palette changes only at half-character boundaries, and force-black and border selection drive the output as required. Only the bench scenarios can show that the pixel bits are unpacked correctly in each of the four modes, that the two-step select-and-write sequence lands in the right entry, and that the ignored command codes really leave the mode unchanged. The bench shows all of these by comparing every output slot with an independent model built from the requirements.

// File: rtl/pxs_pkg.sv
`timescale 1ns/1ps
package pxs_pkg;
    localparam int CW        = 5;              // hardware colour number width
    localparam int PEN_W     = 4;              // pen index width
    localparam int PEN_N     = 1 << PEN_W;     // pens
    localparam int ENTRY_N   = PEN_N + 1;      // pens plus border
    localparam int BORDER_IX = PEN_N;          // border entry index
    localparam int SEL_W     = $clog2(ENTRY_N);
    localparam int SLOT_W    = 4;              // 16 slots per character
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 16;
    localparam logic [CW-1:0] BLACK = CW'(20);

    typedef enum logic [1:0] {
        GM_WIDE16 = 2'd0,
        GM_MED4   = 2'd1,
        GM_FINE2  = 2'd2,
        GM_WIDE4  = 2'd3
    } gmode_e;

    typedef enum logic [1:0] {
        OP_PEN  = 2'd0,
        OP_INK  = 2'd1,
        OP_CTRL = 2'd2,
        OP_EXT  = 2'd3
    } op_e;

    typedef logic [ENTRY_N-1:0][CW-1:0] pal_t;
endpackage

// File: rtl/pxs_regfile.sv
`timescale 1ns/1ps
// Command decode: entry selection, staging palette, pending mode.
module pxs_regfile
    import pxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [BYTE_W-1:0] io_data,
    input  logic              io_wr,
    output pal_t              stage_pal,
    output gmode_e            mode_pend
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        gmode_e           mode;
        pal_t             pal;
    } rf_t;

    rf_t  rf_q, rf_d;
    logic hit;
    op_e  op;

    always_comb begin
        rf_d = rf_q;
        hit  = io_wr && (io_addr[ADDR_W-1:ADDR_W-2] == 2'b01);
        op   = op_e'(io_data[7:6]);
        if (hit) begin
            case (op)
                OP_PEN: begin
                    if (io_data[4]) rf_d.sel = SEL_W'(BORDER_IX);
                    else            rf_d.sel = SEL_W'(io_data[PEN_W-1:0]);
                end
                OP_INK:  rf_d.pal[rf_q.sel] = io_data[CW-1:0];
                OP_CTRL: begin
                    if (!io_data[5]) rf_d.mode = gmode_e'(io_data[1:0]);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_q.sel  <= '0;
            rf_q.mode <= GM_WIDE16;
            for (int i = 0; i < ENTRY_N; i++) rf_q.pal[i] <= BLACK;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign stage_pal = rf_q.pal;
    assign mode_pend = rf_q.mode;

    AST_FOREIGN_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (io_wr && (io_addr[ADDR_W-1:ADDR_W-2] != 2'b01)) |=> ($stable(rf_q.pal) && $stable(rf_q.sel) && $stable(rf_q.mode))) // R1
        else $error("write to foreign address changed state");

    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        rf_q.sel <= SEL_W'(BORDER_IX)) // R2
        else $error("selection out of range");

    AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !io_wr |=> ($stable(rf_q.pal) && $stable(rf_q.mode))) // R3
        else $error("state changed without a write");
endmodule

// File: rtl/pxs_timing.sv
`timescale 1ns/1ps
// Slot counter, per-character byte capture and displayed-mode register.
module pxs_timing
    import pxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] byte_a,
    input  logic [BYTE_W-1:0] byte_b,
    input  gmode_e            mode_pend,
    input  logic              mode_commit,
    output logic [SLOT_W-1:0] slot,
    output logic [BYTE_W-1:0] cur_a,
    output logic [BYTE_W-1:0] cur_b,
    output gmode_e            mode_act,
    output logic              half_edge
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = '1;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BYTE_W-1:0] a;
        logic [BYTE_W-1:0] b;
        gmode_e            mode;
    } tm_t;

    tm_t tm_q, tm_d;

    always_comb begin
        tm_d      = tm_q;
        tm_d.slot = tm_q.slot + 1'b1;
        if (tm_q.slot == LAST_SLOT) begin
            tm_d.a = byte_a;
            tm_d.b = byte_b;
        end
        if (mode_commit) tm_d.mode = mode_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_q.slot <= '0;
            tm_q.a    <= '0;
            tm_q.b    <= '0;
            tm_q.mode <= GM_WIDE16;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign slot      = tm_q.slot;
    assign cur_a     = tm_q.a;
    assign cur_b     = tm_q.b;
    assign mode_act  = tm_q.mode;
    assign half_edge = (tm_q.slot[SLOT_W-2:0] == '1);

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (slot == LAST_SLOT) |=> (slot == '0)) // R5
        else $error("slot counter did not wrap");

    AST_BYTES_HELD: assert property (@(posedge clk) disable iff (rst)
        (slot != LAST_SLOT) |=> ($stable(cur_a) && $stable(cur_b))) // R5
        else $error("video bytes changed mid character");

    AST_MODE_ON_COMMIT_ONLY: assert property (@(posedge clk) disable iff (rst)
        !mode_commit |=> $stable(mode_act)) // R4
        else $error("displayed mode changed without commit");

    AST_MODE_TAKES_PENDING: assert property (@(posedge clk) disable iff (rst)
        mode_commit |=> (mode_act == $past(mode_pend))) // R4
        else $error("commit did not load pending mode");
endmodule

// File: rtl/pxs_unpack.sv
`timescale 1ns/1ps
// Pen index for the current slot from the captured byte pair and mode.
module pxs_unpack
    import pxs_pkg::*;
(
    input  gmode_e            mode,
    input  logic [BYTE_W-1:0] byte_a,
    input  logic [BYTE_W-1:0] byte_b,
    input  logic [SLOT_W-1:0] slot,
    output logic [PEN_W-1:0]  pen_ix
);
    logic [BYTE_W-1:0] src;
    logic [BYTE_W-1:0] sh;
    logic [2:0]        pos;

    always_comb begin
        src = slot[SLOT_W-1] ? byte_b : byte_a;
        pos = slot[2:0];
        // Shift the pixel's own bits into the first pixel's bit positions.
        case (mode)
            GM_FINE2: sh = src << pos;
            GM_MED4:  sh = src << pos[2:1];
            default:  sh = src << pos[2];
        endcase
        case (mode)
            GM_WIDE16: pen_ix = {sh[1], sh[5], sh[3], sh[7]};
            GM_MED4:   pen_ix = {2'b00, sh[3], sh[7]};
            GM_FINE2:  pen_ix = {3'b000, sh[7]};
            default:   pen_ix = {2'b00, sh[3], sh[7]};
        endcase
    end

    AST_NARROW_MODES_PEN_RANGE: assert property (@(posedge slot[0])
        (mode == GM_WIDE16) || (pen_ix[PEN_W-1:2] == 2'b00)) // R7
        else $error("narrow mode produced a pen above 3");
endmodule

// File: rtl/pxs_colour_out.sv
`timescale 1ns/1ps
// Displayed palette (copied from staging at half boundaries) and output mux.
module pxs_colour_out
    import pxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pal_t             stage_pal,
    input  logic             half_edge,
    input  logic [PEN_W-1:0] pen_ix,
    input  logic             disp_en,
    input  logic             force_blk,
    output logic [CW-1:0]    colour
);
    typedef struct packed {
        pal_t          live;
        logic [CW-1:0] col;
    } co_t;

    co_t co_q, co_d;

    always_comb begin
        co_d = co_q;
        if (half_edge) co_d.live = stage_pal;
        if (force_blk)     co_d.col = BLACK;
        else if (!disp_en) co_d.col = co_q.live[BORDER_IX];
        else               co_d.col = co_q.live[{1'b0, pen_ix}];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRY_N; i++) co_q.live[i] <= BLACK;
            co_q.col <= BLACK;
        end else begin
            co_q <= co_d;
        end
    end

    assign colour = co_q.col;

    AST_FORCE_BLACK: assert property (@(posedge clk) disable iff (rst)
        force_blk |=> (colour == BLACK)) // R11
        else $error("force-black not honoured");

    AST_BORDER_SHOWN: assert property (@(posedge clk) disable iff (rst)
        (!force_blk && !disp_en) |=> (colour == $past(co_q.live[BORDER_IX]))) // R11
        else $error("border not shown outside active area");

    AST_LIVE_AT_HALF_ONLY: assert property (@(posedge clk) disable iff (rst)
        !half_edge |=> $stable(co_q.live)) // R10
        else $error("displayed palette changed mid half");
endmodule

// File: rtl/palette_serializer.sv
`timescale 1ns/1ps
module palette_serializer
    import pxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [BYTE_W-1:0] io_data,
    input  logic              io_wr,
    input  logic [BYTE_W-1:0] vid_byte_a,
    input  logic [BYTE_W-1:0] vid_byte_b,
    input  logic              disp_en,
    input  logic              force_blk,
    input  logic              mode_commit,
    output logic [CW-1:0]     colour
);
    pal_t              stage_pal;
    gmode_e            mode_pend;
    gmode_e            mode_act;
    logic [SLOT_W-1:0] slot;
    logic [BYTE_W-1:0] cur_a;
    logic [BYTE_W-1:0] cur_b;
    logic              half_edge;
    logic [PEN_W-1:0]  pen_ix;

    pxs_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .io_addr   (io_addr),
        .io_data   (io_data),
        .io_wr     (io_wr),
        .stage_pal (stage_pal),
        .mode_pend (mode_pend)
    );

    pxs_timing u_timing (
        .clk         (clk),
        .rst         (rst),
        .byte_a      (vid_byte_a),
        .byte_b      (vid_byte_b),
        .mode_pend   (mode_pend),
        .mode_commit (mode_commit),
        .slot        (slot),
        .cur_a       (cur_a),
        .cur_b       (cur_b),
        .mode_act    (mode_act),
        .half_edge   (half_edge)
    );

    pxs_unpack u_unpack (
        .mode   (mode_act),
        .byte_a (cur_a),
        .byte_b (cur_b),
        .slot   (slot),
        .pen_ix (pen_ix)
    );

    pxs_colour_out u_out (
        .clk       (clk),
        .rst       (rst),
        .stage_pal (stage_pal),
        .half_edge (half_edge),
        .pen_ix    (pen_ix),
        .disp_en   (disp_en),
        .force_blk (force_blk),
        .colour    (colour)
    );

    AST_RESET_BLACK: assert property (@(posedge clk)
        $past(rst) |-> (colour == BLACK)) // R12
        else $error("colour not black after reset");
endmodule

// File: tb/palette_serializer_test.sv
`timescale 1ns/1ps
module palette_serializer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_data = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  vid_byte_a = '0;
    logic [7:0]  vid_byte_b = '0;
    logic        disp_en = 1'b0;
    logic        force_blk = 1'b0;
    logic        mode_commit = 1'b0;
    logic [4:0]  colour;

    always #4 clk = ~clk;   // 125 MHz

    palette_serializer uut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_data(io_data), .io_wr(io_wr),
        .vid_byte_a(vid_byte_a), .vid_byte_b(vid_byte_b), .disp_en(disp_en),
        .force_blk(force_blk), .mode_commit(mode_commit), .colour(colour)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // stimulus for the next step
    logic [15:0] t_addr = 16'h7F00;
    logic [7:0]  t_data = '0;
    logic        t_wr = 1'b0, t_de = 1'b0, t_fb = 1'b0, t_commit = 1'b0;
    string       cur_tag = "R12";
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    logic [4:0] m_stage [17];
    logic [4:0] m_live  [17];
    int         m_sel = 0;
    logic [1:0] m_pend = 2'd0, m_act = 2'd0;
    logic [7:0] m_a = '0, m_b = '0;
    int         m_slot = 0;

    logic [4:0] exp_q [$];
    string      tag_q [$];

    function automatic logic [3:0] ref_index(logic [1:0] m, logic [7:0] a, logic [7:0] b, int s);
        logic [7:0] v;
        int p, k;
        v = (s < 8) ? a : b;
        p = s % 8;
        case (m)
            2'd0: ref_index = (p < 4) ? {v[1], v[5], v[3], v[7]} : {v[0], v[4], v[2], v[6]};
            2'd1: begin k = p / 2; ref_index = {2'b00, v[3-k], v[7-k]}; end
            2'd2: ref_index = {3'b000, v[7-p]};
            default: ref_index = (p < 4) ? {2'b00, v[3], v[7]} : {2'b00, v[2], v[6]};
        endcase
    endfunction

    task automatic step();
        logic [4:0] e;
        logic [1:0] old_pend;
        @(negedge clk);
        rst = 1'b0;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        vid_byte_a = lfsr[7:0];
        vid_byte_b = lfsr[15:8] ^ 8'h5A;
        io_addr = t_addr; io_data = t_data; io_wr = t_wr;
        disp_en = t_de; force_blk = t_fb; mode_commit = t_commit;
        if (t_fb)       e = 5'd20;
        else if (!t_de) e = m_live[16];
        else            e = m_live[ref_index(m_act, m_a, m_b, m_slot)];
        exp_q.push_back(e);
        tag_q.push_back(cur_tag);
        // model the clock edge
        old_pend = m_pend;
        if ((m_slot % 8) == 7) for (int i = 0; i < 17; i++) m_live[i] = m_stage[i];
        if (t_wr && t_addr[15:14] == 2'b01) begin
            case (t_data[7:6])
                2'b00: m_sel = t_data[4] ? 16 : int'(t_data[3:0]);
                2'b01: m_stage[m_sel] = t_data[4:0];
                2'b10: if (!t_data[5]) m_pend = t_data[1:0];
                default: ;
            endcase
        end
        if (t_commit) m_act = old_pend;
        if (m_slot == 15) begin m_a = vid_byte_a; m_b = vid_byte_b; end
        m_slot = (m_slot + 1) % 16;
        t_wr = 1'b0;
        t_commit = 1'b0;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_slot(int s);
        while (m_slot != s) step();
    endtask

    task automatic io_write(logic [15:0] a, logic [7:0] d);
        t_addr = a; t_data = d; t_wr = 1'b1;
        step();
        t_addr = 16'h7F00;
    endtask

    task automatic commit_at_boundary();
        wait_slot(15);
        t_commit = 1'b1;
        step();
    endtask

    // monitor: compares each registered output with the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [4:0] e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                n_tests++;
                if (colour !== e) begin
                    n_fail++;
                    $display("FAIL %s: colour=%0d expected %0d", tg, colour, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R5: watchdog expired, run not complete (expected completion)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 17; i++) begin m_stage[i] = 5'd20; m_live[i] = 5'd20; end
        // R12: reset state
        repeat (3) @(negedge clk);
        n_tests++;
        if (colour !== 5'd20) begin
            n_fail++;
            $display("FAIL R12: colour=%0d expected 20 in reset", colour);
        end
        cur_tag = "R12";
        t_de = 1'b1;
        steps(32);

        // R3 / R2: load all pens and the border, shown on border while loading
        cur_tag = "R3";
        t_de = 1'b0;
        for (int i = 0; i < 16; i++) begin
            io_write(16'h7F00, 8'(i));
            io_write(16'h7F00, 8'h40 | 8'((i * 7 + 3) % 32));
        end
        io_write(16'h7F00, 8'h10);
        io_write(16'h7F00, 8'h40 | 8'd9);
        steps(20);

        // R6: mode 0
        cur_tag = "R6";
        t_de = 1'b1;
        steps(96);

        // R4: pending mode without commit stays in mode 0
        cur_tag = "R4";
        io_write(16'h7F00, 8'h81);
        steps(40);
        commit_at_boundary();

        // R7: mode 1
        cur_tag = "R7";
        steps(96);

        // R8: mode 2
        cur_tag = "R8";
        io_write(16'h7FFF, 8'h82);
        commit_at_boundary();
        steps(96);

        // R9: mode 3
        cur_tag = "R9";
        io_write(16'h7F00, 8'h83);
        commit_at_boundary();
        steps(96);

        // R4: ghost control and top-code writes leave mode 3 in place
        cur_tag = "R4";
        io_write(16'h7F00, 8'hA1);
        io_write(16'h7F00, 8'hC2);
        commit_at_boundary();
        steps(48);

        // R1: address decode, pen 1 selected
        cur_tag = "R1";
        io_write(16'h7F00, 8'h01);
        io_write(16'hFF00, 8'h5F);   // bit 15 set: ignored
        io_write(16'h3F00, 8'h40);   // bit 14 clear: ignored
        io_write(16'hBF00, 8'h00);   // both wrong: ignored select
        steps(40);
        io_write(16'h4000, 8'h4B);   // other bits zero: accepted
        steps(40);

        // R10: mid-character palette change on the border
        cur_tag = "R10";
        t_de = 1'b0;
        io_write(16'h7F00, 8'h1F);   // border select, bits 3:0 ignored
        wait_slot(2);
        io_write(16'h7F00, 8'h40 | 8'd14);
        steps(20);
        wait_slot(10);
        io_write(16'h7F00, 8'h40 | 8'd27);
        steps(20);

        // R2: border stays selected across several colour writes
        cur_tag = "R2";
        wait_slot(3);
        io_write(16'h7F00, 8'h40 | 8'd5);
        steps(16);
        wait_slot(3);
        io_write(16'h7F00, 8'h40 | 8'd30);
        steps(20);

        // R11: force-black over border and over active pixels
        cur_tag = "R11";
        t_fb = 1'b1;
        steps(20);
        t_de = 1'b1;
        steps(20);
        t_fb = 1'b0;
        steps(20);
        t_de = 1'b0;
        steps(10);

        // R5: byte capture timing, back in mode 0 with changing bytes
        cur_tag = "R5";
        t_de = 1'b1;
        io_write(16'h7F00, 8'h80);
        commit_at_boundary();
        steps(80);

        steps(2);
        @(negedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule